// File: doc/BRIEF.md
# External Transceiver Handoff Controller

This block governs the handover of the twisted-pair cable to an external 100BASE-T4 transceiver. It drives the T4 ability bit in the outgoing advertisement. That bit is set when a strap input is high or when the software advertisement word already carries it. The remaining ability bits pass through unchanged.

When the negotiation engine reports completion with T4 as the chosen mode, the block enables the external transceiver. In the same step it places the internal transmitter in high impedance. It then gives the external device a bounded number of clock cycles to report link pass. If the link comes up in that time, the block keeps cable control with the external device. If the link never arrives, or drops after it has been established, the block takes the cable back, reactivates the internal transmitter and raises a single-cycle request to restart autonegotiation. The negotiation arbitration itself lives elsewhere. This block only consumes its completion strobe and its result code.

Top module: `xcvr_handoff_ctrl`

## Requirements
- R1: `adv_t4_o` and bit `T4_BIT` (default 4) of `adv_word_o` are 1 whenever `adv_pin_i` is 1 or bit `T4_BIT` of `adv_reg_i` is 1, and 0 otherwise. Both outputs are combinational.
- R2: Every bit of `adv_word_o` other than `T4_BIT` equals the same bit of `adv_reg_i`.
- R3: A clock edge that sees `neg_done_i`=1 with `neg_mode_i`=`MODE_T4` (default 3'd4) while the block is idle raises `ext_en_o` and `tx_hiz_o` from the next cycle on.
- R4: A completion strobe carrying any other mode code leaves `ext_en_o`, `tx_hiz_o` and `restart_o` at 0.
- R5: If `ext_link_i` is 1 on any of the first `LINK_WAIT` edges after the enable rises, the handoff is held. `ext_en_o` and `tx_hiz_o` then stay 1 and `restart_o` stays 0 for as long as `ext_link_i` stays 1.
- R6: If `ext_link_i` stays 0 for all `LINK_WAIT` edges after the enable rises, then after the `LINK_WAIT`-th edge `ext_en_o` and `tx_hiz_o` are 0 and `restart_o` is 1.
- R7: While the handoff is held, an edge that sees `ext_link_i`=0 clears `ext_en_o` and `tx_hiz_o` and raises `restart_o` for the next cycle.
- R8: `restart_o` is never high for two cycles in a row.
- R9: While `rst_n` is low at a clock edge, all outputs clear after that edge: `ext_en_o`, `tx_hiz_o` and `restart_o` go to 0.
- R10: `tx_hiz_o` always equals `ext_en_o`.
- R11: A completion strobe is ignored while the external device is enabled. `ext_link_i` is ignored while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_pin_i | input | 1 | Strap input requesting T4 advertisement |
| adv_reg_i | input | ABIL_W | Software advertisement ability bits |
| adv_word_o | output | ABIL_W | Advertisement bits with T4 merged in |
| adv_t4_o | output | 1 | Merged T4 ability bit |
| neg_done_i | input | 1 | One-cycle negotiation completion strobe |
| neg_mode_i | input | MODE_W | Mode code chosen by negotiation |
| ext_link_i | input | 1 | Link pass reported by the external transceiver |
| ext_en_o | output | 1 | Enable for the external transceiver |
| tx_hiz_o | output | 1 | Internal transmitter high-impedance control |
| restart_o | output | 1 | One-cycle autonegotiation restart request |

## Verification
The bench builds the block with `LINK_WAIT` set to 8 and keeps the default 8-bit ability field and 3-bit mode code. A window of 8 cycles lets the bench walk the whole link-wait interval edge by edge. It can therefore hit both sides of the deadline: a link that arrives on the last permitted edge, and a timeout that fires exactly one edge later. A default-sized wait of hundreds of thousands of cycles could not be reached in a short run.

// File: rtl/xh_pkg.sv
// Package xh_pkg: shared types for the external transceiver handoff block.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package xh_pkg;

    // Handoff controller state: internal transmitter active, waiting for
    // external link, or external device holding the cable.
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_HELD = 2'd2
    } hs_state_t;

endpackage

// File: rtl/xh_adv_merge.sv
// Module xh_adv_merge: merges the T4 strap into the advertisement ability
// bits. Pure combinational; assumes T4_BIT < ABIL_W.
module xh_adv_merge #(
    parameter int ABIL_W = 8,
    parameter int T4_BIT = 4
) (
    input  logic              strap_i,
    input  logic [ABIL_W-1:0] word_i,
    output logic [ABIL_W-1:0] word_o
);

    // One slice per ability bit; only the T4 position takes the strap.
    for (genvar b = 0; b < ABIL_W; b++) begin : g_bit
        if (b == T4_BIT) begin : g_t4
            assign word_o[b] = word_i[b] | strap_i;
        end else begin : g_pass
            assign word_o[b] = word_i[b];
        end
    end

endmodule

// File: rtl/xh_link_timer.sv
// Module xh_link_timer: counts cycles while run_i is high and flags the
// last permitted cycle of the link-wait window. Assumes LINK_WAIT >= 2.
module xh_link_timer #(
    parameter int LINK_WAIT = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);

    localparam int CNT_W = $clog2(LINK_WAIT);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LINK_WAIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Flag the final wait cycle.
    assign last_o = (cnt_q == LAST_V);

    // Count up while running, saturating at the last value; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (!last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/xh_handoff_fsm.sv
// Module xh_handoff_fsm: sequences idle -> wait for external link -> held,
// falling back with a one-cycle restart pulse on timeout or link loss.
// Assumes done_i is a single-cycle strobe and sel_t4_i is valid with it.
module xh_handoff_fsm
    import xh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      done_i,
    input  logic      sel_t4_i,
    input  logic      link_i,
    input  logic      wait_last_i,
    output hs_state_t state_o,
    output logic      restart_o
);

    hs_state_t st_q, st_d;
    logic      rst_req_d, rst_req_q;

    // Next-state and fallback decision.
    always_comb begin
        st_d      = st_q;
        rst_req_d = 1'b0;
        unique case (st_q)
            HS_IDLE: begin
                if (done_i && sel_t4_i) st_d = HS_WAIT;
            end
            HS_WAIT: begin
                if (link_i) begin
                    st_d = HS_HELD;
                end else if (wait_last_i) begin
                    st_d      = HS_IDLE;
                    rst_req_d = 1'b1;
                end
            end
            HS_HELD: begin
                if (!link_i) begin
                    st_d      = HS_IDLE;
                    rst_req_d = 1'b1;
                end
            end
            default: st_d = HS_IDLE;
        endcase
    end

    // State and restart pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= HS_IDLE;
            rst_req_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            rst_req_q <= rst_req_d;
        end
    end

    assign state_o   = st_q;
    assign restart_o = rst_req_q;

endmodule

// File: rtl/xcvr_handoff_ctrl.sv
// Module xcvr_handoff_ctrl: top of the external transceiver handoff block.
// Merges the T4 advertisement, and after a T4 negotiation result hands the
// cable to the external device for as long as its link holds.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module xcvr_handoff_ctrl
    import xh_pkg::*;
#(
    parameter int                ABIL_W    = 8,
    parameter int                T4_BIT    = 4,
    parameter int                MODE_W    = 3,
    parameter logic [MODE_W-1:0] MODE_T4   = 3'd4,
    parameter int                LINK_WAIT = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_pin_i,
    input  logic [ABIL_W-1:0] adv_reg_i,
    output logic [ABIL_W-1:0] adv_word_o,
    output logic              adv_t4_o,
    input  logic              neg_done_i,
    input  logic [MODE_W-1:0] neg_mode_i,
    input  logic              ext_link_i,
    output logic              ext_en_o,
    output logic              tx_hiz_o,
    output logic              restart_o
);

    hs_state_t st_q;
    logic      wait_last;
    logic      sel_t4;

    // Decode the negotiated mode.
    assign sel_t4 = (neg_mode_i == MODE_T4);

    xh_adv_merge #(
        .ABIL_W (ABIL_W),
        .T4_BIT (T4_BIT)
    ) adv_i (
        .strap_i (adv_pin_i),
        .word_i  (adv_reg_i),
        .word_o  (adv_word_o)
    );

    assign adv_t4_o = adv_word_o[T4_BIT];

    xh_link_timer #(
        .LINK_WAIT (LINK_WAIT)
    ) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q == HS_WAIT),
        .last_o (wait_last)
    );

    xh_handoff_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (neg_done_i),
        .sel_t4_i    (sel_t4),
        .link_i      (ext_link_i),
        .wait_last_i (wait_last),
        .state_o     (st_q),
        .restart_o   (restart_o)
    );

    // External device owns the cable in every state but idle.
    assign ext_en_o = (st_q != HS_IDLE);
    assign tx_hiz_o = (st_q == HS_WAIT) || (st_q == HS_HELD);

endmodule

// File: rtl/xcvr_handoff_chk.sv
// Module xcvr_handoff_chk: assertion checker bound into xcvr_handoff_ctrl.
// Assumes it observes the top ports and the controller state.
module xcvr_handoff_chk
    import xh_pkg::*;
#(
    parameter int                MODE_W    = 3,
    parameter logic [MODE_W-1:0] MODE_T4   = 3'd4,
    parameter int                LINK_WAIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              neg_done_i,
    input logic [MODE_W-1:0] neg_mode_i,
    input logic              ext_link_i,
    input logic              ext_en_o,
    input logic              tx_hiz_o,
    input logic              restart_o,
    input hs_state_t         st
);

    localparam int RUN_W = $clog2(LINK_WAIT + 1) + 1;

    logic [RUN_W-1:0] wait_run;

    // Length of the current stay in the wait state.
    always_ff @(posedge clk) begin
        if (!rst_n)              wait_run <= '0;
        else if (st == HS_WAIT)  wait_run <= wait_run + 1'b1;
        else                     wait_run <= '0;
    end

    a_r3_enable_on_t4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en_o && neg_done_i && neg_mode_i == MODE_T4) |=> (ext_en_o && tx_hiz_o));

    a_r4_other_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en_o && neg_done_i && neg_mode_i != MODE_T4) |=> (!ext_en_o && !restart_o));

    a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wait_run <= RUN_W'(LINK_WAIT));

    a_r6_timeout_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HS_WAIT && wait_run == RUN_W'(LINK_WAIT - 1) && !ext_link_i)
        |=> (restart_o && !ext_en_o));

    a_r7_loss_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st == HS_HELD && !ext_link_i) |=> (restart_o && !ext_en_o && !tx_hiz_o));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> !restart_o);

    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!ext_en_o && !tx_hiz_o && !restart_o));

    a_r10_hiz_tracks_en: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hiz_o == ext_en_o);

endmodule

bind xcvr_handoff_ctrl xcvr_handoff_chk #(
    .MODE_W    (MODE_W),
    .MODE_T4   (MODE_T4),
    .LINK_WAIT (LINK_WAIT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .neg_done_i (neg_done_i),
    .neg_mode_i (neg_mode_i),
    .ext_link_i (ext_link_i),
    .ext_en_o   (ext_en_o),
    .tx_hiz_o   (tx_hiz_o),
    .restart_o  (restart_o),
    .st         (st_q)
);

// File: tb/xcvr_handoff_ctrl_tb_top.sv
// Bench for xcvr_handoff_ctrl: table-driven advertisement checks, then
// directed handoff, timeout, link-loss and reset scenarios.
module xcvr_handoff_ctrl_tb_top;

    localparam int LW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv_pin_i = 1'b0;
    logic [7:0] adv_reg_i = '0;
    logic [7:0] adv_word_o;
    logic       adv_t4_o;
    logic       neg_done_i = 1'b0;
    logic [2:0] neg_mode_i = '0;
    logic       ext_link_i = 1'b0;
    logic       ext_en_o, tx_hiz_o, restart_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    xcvr_handoff_ctrl #(.LINK_WAIT(LW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_pin_i  (adv_pin_i),
        .adv_reg_i  (adv_reg_i),
        .adv_word_o (adv_word_o),
        .adv_t4_o   (adv_t4_o),
        .neg_done_i (neg_done_i),
        .neg_mode_i (neg_mode_i),
        .ext_link_i (ext_link_i),
        .ext_en_o   (ext_en_o),
        .tx_hiz_o   (tx_hiz_o),
        .restart_o  (restart_o)
    );

    // {pin, reg[7:0], expected word[7:0]}
    localparam logic [16:0] ADV_VEC [7] = '{
        {1'b0, 8'h00, 8'h00},
        {1'b1, 8'h00, 8'h10},
        {1'b0, 8'h10, 8'h10},
        {1'b1, 8'h10, 8'h10},
        {1'b1, 8'hA3, 8'hB3},
        {1'b0, 8'hEF, 8'hEF},
        {1'b1, 8'hEF, 8'hFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock edge, returning at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_done(input logic [2:0] mode);
        neg_mode_i = mode;
        neg_done_i = 1'b1;
        step();
        neg_done_i = 1'b0;
    endtask

    task automatic check_outs(input string req, input logic en, input logic rs);
        check({req, " ext_en"}, 32'(ext_en_o), 32'(en));
        check({req, " tx_hiz"}, 32'(tx_hiz_o), 32'(en));
        check({req, " restart"}, 32'(restart_o), 32'(rs));
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step();
        step();
        // R9 reset state
        check_outs("R9 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        step();

        // R1 R2 advertisement table
        foreach (ADV_VEC[i]) begin
            adv_pin_i = ADV_VEC[i][16];
            adv_reg_i = ADV_VEC[i][15:8];
            #1;
            check("R1 R2 adv word", 32'(adv_word_o), 32'(ADV_VEC[i][7:0]));
            check("R1 adv t4", 32'(adv_t4_o), 32'(ADV_VEC[i][4]));
        end

        // R11 link in idle ignored
        ext_link_i = 1'b1;
        step();
        step();
        check_outs("R11 link idle", 1'b0, 1'b0);
        ext_link_i = 1'b0;

        // R4 non-T4 modes
        pulse_done(3'd3);
        check_outs("R4 mode3", 1'b0, 1'b0);
        pulse_done(3'd0);
        check_outs("R4 mode0", 1'b0, 1'b0);

        // R3 T4 selected
        pulse_done(3'd4);
        check_outs("R3 enable", 1'b1, 1'b0);

        // R5 link arrives on third wait edge
        step();
        step();
        ext_link_i = 1'b1;
        step();
        for (int k = 0; k < 20; k++) step();
        check_outs("R5 held", 1'b1, 1'b0);

        // R11 strobe ignored while held
        pulse_done(3'd4);
        check_outs("R11 done held", 1'b1, 1'b0);
        pulse_done(3'd1);
        check_outs("R11 other held", 1'b1, 1'b0);

        // R7 link loss then R8 single pulse
        ext_link_i = 1'b0;
        step();
        check_outs("R7 loss", 1'b0, 1'b1);
        step();
        check_outs("R8 pulse end", 1'b0, 1'b0);

        // R6 timeout exact boundary
        pulse_done(3'd4);
        for (int k = 0; k < LW - 1; k++) step();
        check_outs("R6 before deadline", 1'b1, 1'b0);
        step();
        check_outs("R6 timeout", 1'b0, 1'b1);
        step();
        check_outs("R8 after timeout", 1'b0, 1'b0);

        // R5 link on the last permitted edge
        pulse_done(3'd4);
        for (int k = 0; k < LW - 1; k++) step();
        ext_link_i = 1'b1;
        step();
        check_outs("R5 last edge", 1'b1, 1'b0);
        step();
        check_outs("R5 last edge hold", 1'b1, 1'b0);

        // R9 reset while held
        rst_n = 1'b0;
        step();
        check_outs("R9 reset held", 1'b0, 1'b0);
        rst_n = 1'b1;
        step();
        check_outs("R11 link after reset", 1'b0, 1'b0);
        ext_link_i = 1'b0;
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule